// File: doc/BRIEF.md
# Interrupt Enable and Steering Unit

This block merges four interrupt request lines into the two interrupt inputs of a processor core: a normal-priority line (IRQ) and a fast line (FIQ). Two of the request lines come from outside the chip: a fast request and a normal request. The other two come from on-chip units: a performance monitor and a bus controller. Each line has its own enable bit. The two external lines have fixed destinations. Each of the two internal lines can be sent to either output by a steering bit.

Software reaches three registers through a plain register port. The port has a two-bit index, a write strobe, write data, and combinational read data.

- **Control register:** holds the four enable bits.
- **Source register:** read-only. It reports every request that is asserted and enabled at that moment.
- **Steer register:** holds the two steering bits.

Both processor outputs come from flip-flops. Each output therefore reflects the requests and register contents of the previous clock cycle.

Top module: `intr_steer_unit`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, the control and steer registers read as zero and `irq_o` and `fiq_o` are low.
- R2: A write at index 0 stores `reg_wdata_i[3:0]` into the control register: bit 0 enables fast, bit 1 normal, bit 2 performance monitor, bit 3 bus controller. A read at index 0 returns those four bits, and all other bits read zero.
- R3: A write at index 2 stores `reg_wdata_i[1:0]` into the steer register: bit 0 steers the performance monitor, bit 1 the bus controller. A read at index 2 returns those two bits, and all other bits read zero.
- R4: A read at index 1 returns, in the same cycle, bit 28 = performance monitor, bit 29 = bus controller, bit 30 = normal and bit 31 = fast. Each of these bits is set only when its request is high and its enable bit is set. All other bits read zero.
- R5: Writes at index 1 and at index 3 change neither register. A read at index 3 returns zero.
- R6: An enabled fast request drives `fiq_o` and never drives `irq_o`.
- R7: An enabled normal request drives `irq_o` and never drives `fiq_o`.
- R8: An enabled performance monitor request drives `irq_o` when steer bit 0 is 0, and drives `fiq_o` when that bit is 1.
- R9: An enabled bus controller request drives `irq_o` when steer bit 1 is 0, and drives `fiq_o` when that bit is 1.
- R10: `irq_o` and `fiq_o` are registered. Each takes the value given by R6 to R9 from the requests and register contents of the preceding clock cycle. A register write applies to the outputs from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_fast_i | input | 1 | External fast interrupt request |
| req_norm_i | input | 1 | External normal interrupt request |
| req_perf_i | input | 1 | Performance monitor interrupt request |
| req_bus_i | input | 1 | Bus controller interrupt request |
| reg_addr_i | input | 2 | Register index |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Registered normal interrupt to the core |
| fiq_o | output | 1 | Registered fast interrupt to the core |

## Verification
The bench builds the block with the default DATA_W of 32. At this width the source bits at positions 28 to 31 exist, and the bench can check that every other bit of each register reads zero. Random write and read traffic is spread over all four indices, including the unmapped index and writes to the read-only register. The four request lines toggle at the same time. Together these cover every combination of enable and steer bit against the live requests. The cases include a write and a request change in the same cycle, which shows the one-cycle lag of the outputs.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int ADDR_W    = 2;
    localparam int IDX_CTL   = 0;
    localparam int IDX_SRC   = 1;
    localparam int IDX_STEER = 2;

    localparam int CTL_W     = 4;
    localparam int STEER_W   = 2;
    localparam int NUM_INT   = 2;   // steerable on-chip sources

    localparam int EN_FAST   = 0;
    localparam int EN_NORM   = 1;
    localparam int EN_PERF   = 2;
    localparam int EN_BUS    = 3;

    localparam int SRC_PERF  = 28;
    localparam int SRC_BUS   = 29;
    localparam int SRC_NORM  = 30;
    localparam int SRC_FAST  = 31;

    typedef struct packed {
        logic fast;
        logic norm;
        logic perf;
        logic bus;
    } req_t;
endpackage

// File: rtl/isu_regs.sv
module isu_regs
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [CTL_W-1:0]    ctl_q,
    output logic [STEER_W-1:0]  steer_q
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CTL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            steer_q <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(IDX_CTL))
                ctl_q <= wdata[CTL_W-1:0];
            if (addr == ADDR_W'(IDX_STEER))
                steer_q <= wdata[STEER_W-1:0];
        end
    end

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(IDX_CTL)) |=> ctl_q == $past(wdata[CTL_W-1:0]));

    // R3
    steer_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(IDX_STEER)) |=> steer_q == $past(wdata[STEER_W-1:0]));

    // R5
    no_side_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == ADDR_W'(IDX_SRC) || addr == ADDR_W'(3)))
            |=> ($stable(ctl_q) && $stable(steer_q)));
endmodule

// File: rtl/isu_route.sv
module isu_route
    import isu_pkg::*;
(
    input  req_t                req,
    input  logic [CTL_W-1:0]    ctl,
    input  logic [STEER_W-1:0]  steer,
    output req_t                live,
    output logic                irq_d,
    output logic                fiq_d
);
    logic [NUM_INT-1:0] int_live;
    logic [NUM_INT-1:0] to_irq;
    logic [NUM_INT-1:0] to_fiq;

    always_comb begin
        live.fast = req.fast & ctl[EN_FAST];
        live.norm = req.norm & ctl[EN_NORM];
        live.perf = req.perf & ctl[EN_PERF];
        live.bus  = req.bus  & ctl[EN_BUS];
    end

    assign int_live[0] = live.perf;
    assign int_live[1] = live.bus;

    for (genvar i = 0; i < NUM_INT; i++) begin : g_steer
        assign to_fiq[i] = int_live[i] &  steer[i];
        assign to_irq[i] = int_live[i] & ~steer[i];
    end

    assign irq_d = live.norm | (|to_irq);
    assign fiq_d = live.fast | (|to_fiq);
endmodule

// File: rtl/isu_readback.sv
module isu_readback
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CTL_W-1:0]    ctl,
    input  logic [STEER_W-1:0]  steer,
    input  req_t                live,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(IDX_CTL):   rdata[CTL_W-1:0] = ctl;
            ADDR_W'(IDX_SRC): begin
                rdata[SRC_PERF] = live.perf;
                rdata[SRC_BUS]  = live.bus;
                rdata[SRC_NORM] = live.norm;
                rdata[SRC_FAST] = live.fast;
            end
            ADDR_W'(IDX_STEER): rdata[STEER_W-1:0] = steer;
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_steer_unit.sv
module intr_steer_unit
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fast_i,
    input  logic              req_norm_i,
    input  logic              req_perf_i,
    input  logic              req_bus_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    req_t               req;
    req_t               live;
    logic [CTL_W-1:0]   ctl_q;
    logic [STEER_W-1:0] steer_q;
    logic               irq_d;
    logic               fiq_d;

    assign req.fast = req_fast_i;
    assign req.norm = req_norm_i;
    assign req.perf = req_perf_i;
    assign req.bus  = req_bus_i;

    isu_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .ctl_q   (ctl_q),
        .steer_q (steer_q)
    );

    isu_route u_route (
        .req   (req),
        .ctl   (ctl_q),
        .steer (steer_q),
        .live  (live),
        .irq_d (irq_d),
        .fiq_d (fiq_d)
    );

    isu_readback #(.DATA_W(DATA_W)) u_readback (
        .addr  (reg_addr_i),
        .ctl   (ctl_q),
        .steer (steer_q),
        .live  (live),
        .rdata (reg_rdata_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
        end
    end

    // R6
    fast_to_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fast_i && ctl_q[EN_FAST]) |=> fiq_o);

    // R7
    norm_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_norm_i && ctl_q[EN_NORM]) |=> irq_o);

    // R8
    perf_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_perf_i && ctl_q[EN_PERF]) |=> (steer_q[0] ? fiq_o : irq_o) || $past(reg_wr_i));

    // R9
    bus_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_bus_i && ctl_q[EN_BUS]) |=> (steer_q[1] ? fiq_o : irq_o) || $past(reg_wr_i));

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_fast_i && !req_norm_i && !req_perf_i && !req_bus_i) |=> (!irq_o && !fiq_o));
endmodule

// File: tb/intr_steer_unit_tb.sv
module intr_steer_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int N_RANDOM   = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_fast_i = 1'b0, req_norm_i = 1'b0;
    logic              req_perf_i = 1'b0, req_bus_i = 1'b0;
    logic [1:0]        reg_addr_i = '0;
    logic              reg_wr_i = 1'b0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o, fiq_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_ctl = 0, m_st = 0;
    bit m_irq = 0, m_fiq = 0;

    intr_steer_unit #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_fast_i(req_fast_i), .req_norm_i(req_norm_i),
        .req_perf_i(req_perf_i), .req_bus_i(req_bus_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit en(int b);
        return ((m_ctl >> b) & 1) != 0;
    endfunction

    function automatic bit st(int b);
        return ((m_st >> b) & 1) != 0;
    endfunction

    function automatic logic [31:0] exp_read();
        logic [31:0] v = '0;
        case (reg_addr_i)
            2'd0: v = 32'(m_ctl);
            2'd1: begin
                v[28] = req_perf_i & en(2);
                v[29] = req_bus_i  & en(3);
                v[30] = req_norm_i & en(1);
                v[31] = req_fast_i & en(0);
            end
            2'd2: v = 32'(m_st);
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        bit ni, nf;
        if (!rst_n) begin
            m_ctl = 0; m_st = 0; m_irq = 0; m_fiq = 0;
        end else begin
            nf = (req_fast_i && en(0)) || (req_perf_i && en(2) && st(0))
              || (req_bus_i && en(3) && st(1));
            ni = (req_norm_i && en(1)) || (req_perf_i && en(2) && !st(0))
              || (req_bus_i && en(3) && !st(1));
            m_irq = ni; m_fiq = nf;
            if (reg_wr_i && reg_addr_i == 2'd0) m_ctl = int'(reg_wdata_i % 16);
            if (reg_wr_i && reg_addr_i == 2'd2) m_st  = int'(reg_wdata_i % 4);
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rtag;
        case (reg_addr_i)
            2'd0: rtag = "R2 control read";
            2'd1: rtag = "R4 source read";
            2'd2: rtag = "R3 steer read";
            default: rtag = "R5 unmapped read";
        endcase
        check(rtag, reg_rdata_o, exp_read());
        check("R10 irq (R7 R8 R9)", {31'd0, irq_o}, {31'd0, m_irq});
        check("R10 fiq (R6 R8 R9)", {31'd0, fiq_o}, {31'd0, m_fiq});
    endtask

    task automatic step(bit f, bit n, bit p, bit b, logic [1:0] a, bit w, logic [31:0] d);
        @(negedge clk);
        compare_all();
        req_fast_i = f; req_norm_i = n; req_perf_i = p; req_bus_i = b;
        reg_addr_i = a; reg_wr_i = w; reg_wdata_i = d;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state with requests high
        step(1, 1, 1, 1, 2'd0, 1, 32'hFFFF_FFFF);
        step(1, 1, 1, 1, 2'd2, 1, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R1 ctl reset", reg_rdata_o, 32'd0);   // index 2 at reset
        check("R1 irq reset", {31'd0, irq_o}, 32'd0);
        check("R1 fiq reset", {31'd0, fiq_o}, 32'd0);
        rst_n = 1'b1;
        reg_wr_i = 1'b0;
        step(1, 1, 1, 1, 2'd1, 0, 0);
        // R1: outputs still low one cycle after reset release (all disabled)
        step(0, 0, 0, 0, 2'd0, 1, 32'hFFFF_FFF5);  // R2 enable fast+perf, upper bits dropped
        step(1, 0, 1, 0, 2'd1, 0, 0);              // R6 fast -> fiq, R8 perf -> irq
        step(1, 0, 1, 0, 2'd1, 0, 0);
        step(0, 0, 1, 0, 2'd2, 1, 32'hFFFF_FFFD);  // R3 steer perf to fiq
        step(0, 0, 1, 0, 2'd2, 0, 0);
        step(0, 0, 1, 0, 2'd1, 1, 32'h0000_000F);  // R5 write to source ignored
        step(0, 1, 0, 1, 2'd3, 1, 32'h0000_000F);  // R5 write to index 3 ignored
        step(0, 1, 0, 1, 2'd0, 1, 32'h0000_000A);  // R7 normal, R9 bus
        step(0, 1, 0, 1, 2'd2, 1, 32'h0000_0002);  // R9 bus to fiq
        step(1, 1, 1, 1, 2'd1, 1, 32'h0000_0000);
        step(1, 1, 1, 1, 2'd1, 0, 0);
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0], r[1], r[2], r[3], 2'($urandom), 1'($urandom), $urandom);
        end
        step(0, 0, 0, 0, 2'd0, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule